// File: doc/BRIEF.md
# Fuse Line Programming Sequencer

This block programs one line of a one-time-programmable fuse array. A line holds 64 data bits, split into a low and a high 32-bit word, plus a lock word whose bit 0 is the lock flag. A request carries a line index, a 64-bit value, a 32-bit mask for each data word and a lock request. The sequencer first screens the request. If it may proceed, the sequencer raises the program-enable control and reads the line. A line that is already locked is refused. Otherwise the masked new bits are ORed into the stored bits, and the line is written back as three timed steps: low word, high word, lock word. Each step is followed by a settle wait. Program-enable is dropped after the last wait, or after a refusal, and a one-cycle `done` pulse then reports a result code.

The fuse array is modelled as a register file inside the block. It clears to all zeros on reset, which stands for unblown fuses. An observation port reads any line back combinationally.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high, and all request fields are sampled at that edge. While the block is busy, `req_ready` stays low and anything on the request pins is ignored. The result has no back-pressure: `err` is meaningful in the single cycle where `done` is high.

Top module: `fuse_line_prog`

## Requirements
- R1: A line index of 64 or above completes with code 1 (no device), and program-enable never rises. This check wins over every other fault.
- R2: A request whose lock request is 0, with the index in range, completes with code 2 (invalid) and nothing is programmed.
- R3: A request with any of data bits 63..57 set completes with code 2 and nothing is programmed. These are reserved ECC bits. The check is made after the index check and the lock-request check.
- R4: A valid request whose 64 data bits are all zero, while either mask is nonzero, completes with code 0 and does no programming: no write strobe and no program-enable.
- R5: If the stored lock bit of the line is 1, the request completes with code 3 (permission). Program-enable rises and falls again, no write strobe occurs, and the line is unchanged. A locked line never unlocks.
- R6: On a successful write, the low word becomes old | (data[31:0] & mask_lo), the high word becomes old | (data[63:32] & mask_hi), and the lock bit becomes 1. Fuse bits never change from 1 to 0.
- R7: A successful write gives exactly three `wr_stb` cycles. `wr_word` is 0 (low), then 1 (high), then 2 (lock), and consecutive strobes are CYC_PER_MS+1 cycles apart.
- R8: Program-enable is high during every write strobe and low when `done` is high. `done` comes exactly 5*CYC_PER_MS+2 cycles after the lock-word strobe.
- R9: `done` lasts one cycle and carries `err`. `busy` is high from the cycle after acceptance through the `done` cycle, and is low with `req_ready` high in the cycle that follows. After reset the block is idle, every output is low except `req_ready`, and every line reads zero.
- R10: A lock-only request (data zero, both masks zero, lock 1) on an unlocked line sets only the lock bit; the data words keep their contents.
- R11: While busy, `req_valid` is ignored: it starts no request and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_line | input | 7 | Line index; values 64 and above are out of range |
| req_data | input | 64 | New fuse bits; bits 63..57 must be zero |
| req_mask_lo | input | 32 | Mask for data bits 31..0 |
| req_mask_hi | input | 32 | Mask for data bits 63..32 |
| req_lock | input | 1 | Lock request; must be 1 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code: 0 OK, 1 no device, 2 invalid, 3 permission |
| prog_en | output | 1 | Program-enable control to the fuse macro |
| wr_stb | output | 1 | A fuse word is being written this cycle |
| wr_word | output | 2 | Word being written: 0 low, 1 high, 2 lock |
| obs_line | input | 6 | Line selected for read-back |
| obs_data | output | 64 | Data bits of the selected line |
| obs_lock | output | 1 | Lock bit of the selected line |

## Verification
Some rules are checked by assertions on every cycle: the low, high, lock order of the strobes; program-enable covering each strobe and being low at `done`; `done` lasting a single cycle; `busy` falling only after `done`; no write ever reaching a locked line; lock bits that never clear; and data bits that never go from 1 to 0. Other behaviour only the bench scenarios can show. This covers the result code for each fault and the order in which faults are checked, the exact merged contents read back from a line, the cycle spacing of the settle waits, the skip case that programs nothing, and requests offered while busy being ignored.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NODEV = 2'd1,
    ERR_INVAL = 2'd2,
    ERR_PERM  = 2'd3
  } fuse_err_e;

  typedef enum logic [1:0] {
    WORD_LO = 2'd0,
    WORD_HI = 2'd1,
    WORD_LK = 2'd2
  } fuse_word_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_READ,
    S_WR_LO,
    S_WAIT_LO,
    S_WR_HI,
    S_WAIT_HI,
    S_WR_LK,
    S_WAIT_LK,
    S_RELEASE,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/fuse_req_check.sv
module fuse_req_check
  import fuse_prog_pkg::*;
#(
  parameter int LINES   = 64,
  parameter int IW      = 7,
  parameter int HALF    = 32,
  parameter int ECC_LSB = 57
) (
  input  logic [IW-1:0]     line,
  input  logic [2*HALF-1:0] data,
  input  logic [HALF-1:0]   mask_lo,
  input  logic [HALF-1:0]   mask_hi,
  input  logic              lock,
  output logic              fault,
  output logic              skip,
  output logic [1:0]        code
);

  logic ecc_set;
  logic data_zero;
  logic mask_any;

  assign ecc_set   = |data[2*HALF-1:ECC_LSB];
  assign data_zero = (data == '0);
  assign mask_any  = |{mask_lo, mask_hi};

  // Fault priority: range, then lock request, then reserved ECC bits.
  always_comb begin
    fault = 1'b0;
    skip  = 1'b0;
    code  = ERR_NONE;
    if (int'(line) >= LINES) begin
      fault = 1'b1;
      code  = ERR_NODEV;
    end else if (!lock) begin
      fault = 1'b1;
      code  = ERR_INVAL;
    end else if (ecc_set) begin
      fault = 1'b1;
      code  = ERR_INVAL;
    end else if (data_zero && mask_any) begin
      skip = 1'b1;
    end
  end

endmodule

// File: rtl/fuse_settle_timer.sv
module fuse_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // Outside a load the count only moves down; it never wraps. R7
  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt <= $past(cnt))) else $error("settle timer wrapped"); // R7

endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int LINES = 64,
  parameter int HALF  = 32,
  localparam int AW   = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_word,
  input  logic [AW-1:0]   wr_idx,
  input  logic [HALF-1:0] wr_val,
  input  logic [AW-1:0]   rd_idx,
  output logic [HALF-1:0] rd_lo,
  output logic [HALF-1:0] rd_hi,
  output logic            rd_lock,
  input  logic [AW-1:0]   obs_idx,
  output logic [HALF-1:0] obs_lo,
  output logic [HALF-1:0] obs_hi,
  output logic            obs_lock
);

  logic [HALF-1:0] lo_mem [LINES];
  logic [HALF-1:0] hi_mem [LINES];
  logic            lk_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        lo_mem[i] <= '0;
        hi_mem[i] <= '0;
        lk_mem[i] <= 1'b0;
      end
    end else if (wr_en) begin
      case (wr_word)
        2'd0:    lo_mem[wr_idx] <= wr_val;
        2'd1:    hi_mem[wr_idx] <= wr_val;
        default: lk_mem[wr_idx] <= wr_val[0];
      endcase
    end
  end

  assign rd_lo    = lo_mem[rd_idx];
  assign rd_hi    = hi_mem[rd_idx];
  assign rd_lock  = lk_mem[rd_idx];
  assign obs_lo   = lo_mem[obs_idx];
  assign obs_hi   = hi_mem[obs_idx];
  assign obs_lock = lk_mem[obs_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line_ast
    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_idx == AW'(g))) |-> !lk_mem[g]) else $error("write to locked line"); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
      lk_mem[g] |=> lk_mem[g]) else $error("lock bit cleared"); // R5
    AST_BITS_NEVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (((lo_mem[g] & $past(lo_mem[g])) == $past(lo_mem[g])) &&
                ((hi_mem[g] & $past(hi_mem[g])) == $past(hi_mem[g]))))
      else $error("fuse bit went from 1 to 0"); // R6
  end

endmodule

// File: rtl/fuse_line_prog.sv
module fuse_line_prog
  import fuse_prog_pkg::*;
#(
  parameter int LINES      = 64,
  parameter int CYC_PER_MS = 100000,
  parameter int LOCK_MS    = 5,
  parameter int ECC_LSB    = 57
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [6:0]  req_line,
  input  logic [63:0] req_data,
  input  logic [31:0] req_mask_lo,
  input  logic [31:0] req_mask_hi,
  input  logic        req_lock,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err,
  output logic        prog_en,
  output logic        wr_stb,
  output logic [1:0]  wr_word,
  input  logic [5:0]  obs_line,
  output logic [63:0] obs_data,
  output logic        obs_lock
);

  localparam int HALF   = 32;
  localparam int AW     = $clog2(LINES);
  localparam int IW     = AW + 1;
  localparam int LK_CYC = LOCK_MS * CYC_PER_MS;
  localparam int CNT_W  = $clog2(LK_CYC + 1);

  seq_state_e      state;
  logic [IW-1:0]   line_q;
  logic [63:0]     data_q;
  logic [HALF-1:0] mlo_q, mhi_q;
  logic            lock_q;
  logic [1:0]      err_q;
  logic            pen_q;

  logic            chk_fault, chk_skip;
  logic [1:0]      chk_code;
  logic [HALF-1:0] cur_lo, cur_hi;
  logic            cur_lk;
  logic [HALF-1:0] obs_lo, obs_hi;
  logic            t_load, t_tick, t_exp;
  logic [CNT_W-1:0] t_val;
  logic [HALF-1:0] wr_val;

  fuse_req_check #(
    .LINES(LINES), .IW(IW), .HALF(HALF), .ECC_LSB(ECC_LSB)
  ) u_check (
    .line(line_q), .data(data_q), .mask_lo(mlo_q), .mask_hi(mhi_q),
    .lock(lock_q), .fault(chk_fault), .skip(chk_skip), .code(chk_code)
  );

  fuse_array #(.LINES(LINES), .HALF(HALF)) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_stb), .wr_word(wr_word), .wr_idx(line_q[AW-1:0]), .wr_val(wr_val),
    .rd_idx(line_q[AW-1:0]), .rd_lo(cur_lo), .rd_hi(cur_hi), .rd_lock(cur_lk),
    .obs_idx(obs_line[AW-1:0]), .obs_lo(obs_lo), .obs_hi(obs_hi), .obs_lock(obs_lock)
  );

  fuse_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .tick(t_tick), .expired(t_exp)
  );

  // Write strobe and read-merge data
  always_comb begin
    wr_stb  = 1'b0;
    wr_word = WORD_LO;
    wr_val  = '0;
    case (state)
      S_WR_LO: begin
        wr_stb = 1'b1; wr_word = WORD_LO;
        wr_val = cur_lo | (data_q[HALF-1:0] & mlo_q);
      end
      S_WR_HI: begin
        wr_stb = 1'b1; wr_word = WORD_HI;
        wr_val = cur_hi | (data_q[2*HALF-1:HALF] & mhi_q);
      end
      S_WR_LK: begin
        wr_stb = 1'b1; wr_word = WORD_LK;
        wr_val = {{(HALF-1){1'b0}}, cur_lk | lock_q};
      end
      default: ;
    endcase
  end

  // Settle timer control
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (state == S_WR_LO || state == S_WR_HI) begin
      t_load = 1'b1;
      t_val  = CNT_W'(CYC_PER_MS - 1);
    end else if (state == S_WR_LK) begin
      t_load = 1'b1;
      t_val  = CNT_W'(LK_CYC - 1);
    end
  end
  assign t_tick = (state == S_WAIT_LO) || (state == S_WAIT_HI) || (state == S_WAIT_LK);

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      line_q <= '0;
      data_q <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= ERR_NONE;
      pen_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          line_q <= req_line;
          data_q <= req_data;
          mlo_q  <= req_mask_lo;
          mhi_q  <= req_mask_hi;
          lock_q <= req_lock;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          if (chk_fault) begin
            err_q <= chk_code;
            state <= S_DONE;
          end else if (chk_skip) begin
            err_q <= ERR_NONE;
            state <= S_DONE;
          end else begin
            pen_q <= 1'b1;
            state <= S_READ;
          end
        end
        S_READ: begin
          if (cur_lk) begin
            err_q <= ERR_PERM;
            state <= S_RELEASE;
          end else begin
            state <= S_WR_LO;
          end
        end
        S_WR_LO:   state <= S_WAIT_LO;
        S_WAIT_LO: if (t_exp) state <= S_WR_HI;
        S_WR_HI:   state <= S_WAIT_HI;
        S_WAIT_HI: if (t_exp) state <= S_WR_LK;
        S_WR_LK:   state <= S_WAIT_LK;
        S_WAIT_LK: if (t_exp) begin
          err_q <= ERR_NONE;
          state <= S_RELEASE;
        end
        S_RELEASE: begin
          pen_q <= 1'b0;
          state <= S_DONE;
        end
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign err       = err_q;
  assign prog_en   = pen_q;
  assign obs_data  = {obs_hi, obs_lo};

  // Checker state: last word written
  logic [1:0] ast_last;
  always_ff @(posedge clk) begin
    if (rst) ast_last <= WORD_LK;
    else if (wr_stb) ast_last <= wr_word;
  end

  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_word == ((ast_last == WORD_LK) ? WORD_LO : ast_last + 2'd1)))
    else $error("fuse word order broken"); // R7
  AST_PEN_COVERS_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> prog_en) else $error("write without program enable"); // R8
  AST_PEN_LOW_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !prog_en) else $error("program enable left on"); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done)) else $error("busy fell without done"); // R9

endmodule

// File: tb/sim_fuse_line_prog.sv
module sim_fuse_line_prog;

  localparam int MS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_line = '0;
  logic [63:0] req_data = '0;
  logic [31:0] req_mask_lo = '0, req_mask_hi = '0;
  logic        req_lock = 1'b0;
  logic        busy, done, prog_en, wr_stb, obs_lock;
  logic [1:0]  err, wr_word;
  logic [5:0]  obs_line = '0;
  logic [63:0] obs_data;

  fuse_line_prog #(.LINES(64), .CYC_PER_MS(MS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_data(req_data), .req_mask_lo(req_mask_lo),
    .req_mask_hi(req_mask_hi), .req_lock(req_lock), .busy(busy), .done(done),
    .err(err), .prog_en(prog_en), .wr_stb(wr_stb), .wr_word(wr_word),
    .obs_line(obs_line), .obs_data(obs_data), .obs_lock(obs_lock)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [1:0]  err;
    int          line;
    logic [63:0] data;
    logic        lock;
    int          nstb;
    bit          pen;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [63:0] m_data [64];
  logic        m_lock [64];
  int checks = 0, fails = 0;
  int cyc = 0;
  int stb_n = 0, last_stb = 0, lk_stb = 0;
  bit pen_seen = 0, after_done = 0, finished = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Driver: computes the expected result, queues it, offers the request.
  task automatic send(input int line, input logic [63:0] data, input logic [31:0] mlo,
                      input logic [31:0] mhi, input logic lk, input string tag);
    exp_t e;
    e.line = line; e.tag = tag; e.nstb = 0; e.pen = 0; e.err = 2'd0;
    if (line >= 64) e.err = 2'd1;
    else if (!lk) e.err = 2'd2;
    else if (|data[63:57]) e.err = 2'd2;
    else if (data == 64'd0 && (mlo | mhi) != 32'd0) e.err = 2'd0;
    else if (m_lock[line]) begin e.err = 2'd3; e.pen = 1; end
    else begin
      m_data[line] = m_data[line] | (data & {mhi, mlo});
      m_lock[line] = 1'b1;
      e.nstb = 3; e.pen = 1;
    end
    if (line < 64) begin e.data = m_data[line]; e.lock = m_lock[line]; end
    expq.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_line = 7'(line); req_data = data;
    req_mask_lo = mlo; req_mask_hi = mhi; req_lock = lk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    wait (expq.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: strobe timing and scoreboard at done.
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (after_done) begin
        after_done = 0;
        check(!done && !busy && req_ready, "R9", "idle after done",
              {61'd0, done, busy, req_ready}, 64'd1);
      end
      if (prog_en) pen_seen = 1;
      if (wr_stb) begin
        stb_n++;
        check(prog_en, "R8", "prog_en during strobe", 64'(prog_en), 64'd1);
        check(int'(wr_word) == stb_n - 1, "R7", "word order", 64'(wr_word), 64'(stb_n - 1));
        if (stb_n > 1)
          check(cyc - last_stb == MS + 1, "R7", "strobe spacing",
                64'(cyc - last_stb), 64'(MS + 1));
        last_stb = cyc;
        if (wr_word == 2'd2) lk_stb = cyc;
      end
      if (done) begin
        if (expq.size() == 0) begin
          check(0, "R11", "unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(err == e.err, e.tag, "result code", 64'(err), 64'(e.err));
          check(stb_n == e.nstb, e.tag, "strobe count", 64'(stb_n), 64'(e.nstb));
          check(pen_seen == e.pen, e.tag, "program enable seen", 64'(pen_seen), 64'(e.pen));
          check(!prog_en && busy, "R8", "prog_en low, busy high at done",
                {62'd0, prog_en, busy}, 64'd1);
          if (e.nstb == 3)
            check(cyc - lk_stb == 5 * MS + 2, "R8", "lock settle",
                  64'(cyc - lk_stb), 64'(5 * MS + 2));
          if (e.line < 64) begin
            obs_line = 6'(e.line);
            #1;
            check(obs_data == e.data, e.tag, "line data", obs_data, e.data);
            check(obs_lock == e.lock, e.tag, "line lock", 64'(obs_lock), 64'(e.lock));
          end
        end
        stb_n = 0; pen_seen = 0; after_done = 1;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_lock[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    obs_line = 6'd0;
    #1;
    check({busy, done, prog_en, wr_stb, req_ready} == 5'b00001, "R9", "reset outputs",
          64'({busy, done, prog_en, wr_stb, req_ready}), 64'd1);
    check(obs_data == 64'd0 && !obs_lock, "R9", "reset line", obs_data, 64'd0);

    send(64, 64'd1, '1, '1, 1'b1, "R1");           wait_idle();
    send(70, 64'd1 << 60, '1, '1, 1'b0, "R1");     wait_idle();
    send(3, 64'h12, '1, '1, 1'b0, "R2");           wait_idle();
    send(3, (64'd1 << 57) | 64'd5, '1, '1, 1'b1, "R3"); wait_idle();
    send(3, 64'd1 << 63, '1, '1, 1'b0, "R2");      wait_idle();
    send(4, 64'd0, 32'hff, 32'd0, 1'b1, "R4");     wait_idle();
    send(5, 64'h0123_4567_89ab_cdef, '1, '1, 1'b1, "R6"); wait_idle();
    send(5, 64'h00ff_ffff_ffff_ffff, '1, '1, 1'b1, "R5"); wait_idle();
    send(6, 64'h01aa_55aa_f0f0_0f0f, 32'h0000_ffff, 32'hff00_0000, 1'b1, "R6"); wait_idle();
    send(7, 64'd0, 32'd0, 32'd0, 1'b1, "R10");     wait_idle();
    send(7, 64'd1, '1, '1, 1'b1, "R5");            wait_idle();
    send(4, 64'h1, '1, '1, 1'b1, "R6");            wait_idle();

    // R11: offers made while busy are ignored
    send(8, 64'h00de_ad00_0000_beef, '1, '1, 1'b1, "R11");
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_line = 7'd9; req_data = 64'h55; req_lock = 1'b1;
    req_mask_lo = '1; req_mask_hi = '1;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    obs_line = 6'd9;
    #1;
    check(obs_data == 64'd0 && !obs_lock, "R11", "line 9 untouched", obs_data, 64'd0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule